// File: doc/BRIEF.md
# Bidirectional latched bus transceiver

This block connects two parallel buses, A and B, through two independent non-inverting paths: one from A to B and one from B to A. Each path holds its data in a storage stage with three behaviours. It can pass data straight through, hold the last value it had, or capture the source on a rising edge of a strobe input while a capture-enable input allows it. Each path also has its own active-low drive enable. When that enable is deasserted, the path's destination bus is released to high impedance.

All storage runs on one system clock `clk`. The per-path strobe inputs are slow control levels that this clock samples. A rising edge counts when the strobe is sampled high on one clock after being sampled low on the one before. The pass-through selection is combinational, so a path that is passing shows its source on the destination in the same cycle. Reset is synchronous and active low. It clears both stores and releases both buses. Requesting drive on both paths at once is an illegal combination. The block reports it on a flag and releases both buses while it lasts.

Top module: `bus_xcvr`

## Requirements
- R1: Each path copies all 18 source bits, unchanged and in the same bit order, to its destination bus. The A-to-B path and the B-to-A path have separate controls and separate stores, and one path's controls never change the other path's store.
- R2: While a path's drive enable (`*_oe_n`) is 1, its destination bus is high impedance, whatever the other inputs are. A value captured during that time appears once the enable returns to 0.
- R3: While a path's pass input is 1 and the path drives, the destination equals the source in the same cycle.
- R4: With pass at 0, a path captures its source at the clock edge where its strobe is sampled 1 and was sampled 0 at the previous edge, provided its capture-enable (`*_stb_en_n`) is 0 at that edge. The new value appears on the destination after that edge.
- R5: With pass at 0 and no qualified strobe edge, the destination holds its value, and changes on the source have no effect.
- R6: Capture-enable is sampled at the same edge as the data. A strobe edge with capture-enable at 1 is ignored. Capture-enable at 0 at an earlier edge does not qualify a later strobe edge that finds it at 1.
- R7: When pass falls, the path holds the last source value sampled while pass was 1. Pass falling while the strobe is high never causes a capture.
- R8: While `rst_n` is 0, both buses are high impedance whatever the drive enables are. The clock edge that samples `rst_n` at 0 clears both stores to zero. The strobe level is sampled even during reset, so a strobe that is already high when reset is released does not count as an edge.
- R9: While both drive enables are 0, `conflict` is 1 and both buses are high impedance. Otherwise `conflict` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the strobes and updates the stores |
| rst_n | input | 1 | Synchronous active-low reset |
| ab_oe_n | input | 1 | A-to-B drive enable, active low |
| ab_pass | input | 1 | A-to-B pass-through select |
| ab_stb | input | 1 | A-to-B capture strobe level |
| ab_stb_en_n | input | 1 | A-to-B capture enable, active low |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| ba_pass | input | 1 | B-to-A pass-through select |
| ba_stb | input | 1 | B-to-A capture strobe level |
| ba_stb_en_n | input | 1 | B-to-A capture enable, active low |
| bus_a | inout | 18 | A bus: source of A-to-B, destination of B-to-A |
| bus_b | inout | 18 | B bus: source of B-to-A, destination of A-to-B |
| conflict | output | 1 | Both drive enables active at once |

## Verification
The hold and capture properties assume each path's source bus is driven to a defined value whenever that path passes or captures. They also assume strobe and capture-enable levels change only between clock edges. The stimulus therefore drives a bus only from the side that is its source at that moment. It keeps the idle path with pass low and capture-enable high, so that path never samples a bus the block itself is driving. When control of a bus changes hands, the block's drive enable and the stimulus driver switch in the same step. Weak pull-ups on both buses make a released bus read as all ones, so each test pattern avoids that value where isolation is checked.

// File: rtl/bus_xcvr_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the bus transceiver.
// Assumes: a path's storage controls travel together as one struct.
package bus_xcvr_pkg;

    localparam int DATA_W_DEFAULT = 18;

    // Storage controls of one direction.
    typedef struct packed {
        logic pass;      // 1: destination follows source
        logic stb;       // capture strobe level
        logic stb_en_n;  // capture enable, active low
    } store_ctrl_t;

endpackage

// File: rtl/bus_xcvr_edge.sv
`timescale 1ns/1ps
// Module: bus_xcvr_edge
// Detects a low-to-high change of a level sampled on clk.
// Assumes: the level is stable around clock edges. Sampling continues
// through reset, so a level already high at release gives no edge.
module bus_xcvr_edge (
    input  logic clk,
    input  logic lvl,
    output logic rise
);
    logic seen_q;

    // Remember the level from the previous clock.
    always_ff @(posedge clk) begin
        seen_q <= lvl;
    end

    assign rise = lvl & ~seen_q;
endmodule

// File: rtl/bus_xcvr_store.sv
`timescale 1ns/1ps
// Module: bus_xcvr_store
// Storage of one direction: pass-through, hold, or strobe-edge capture
// qualified by an active-low enable sampled at the same edge.
// Assumes: din is defined whenever pass or a qualified edge occurs.
module bus_xcvr_store
    import bus_xcvr_pkg::*;
#(
    parameter int W = DATA_W_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  store_ctrl_t  ctl,
    input  logic [W-1:0] din,
    output logic [W-1:0] val
);
    logic         rise;
    logic         load;
    logic [W-1:0] held_q;

    bus_xcvr_edge u_edge (
        .clk  (clk),
        .lvl  (ctl.stb),
        .rise (rise)
    );

    // Load while passing, or on an enabled strobe edge.
    always_comb begin
        load = ctl.pass | (rise & ~ctl.stb_en_n);
    end

    // Held value: cleared by reset, refreshed when loading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (load) begin
            held_q <= din;
        end
    end

    // Pass-through bypass ahead of the register.
    assign val = ctl.pass ? din : held_q;
endmodule

// File: rtl/bus_xcvr_gate.sv
`timescale 1ns/1ps
// Module: bus_xcvr_gate
// Turns the two active-low drive requests into driver enables.
// Assumes: simultaneous requests are illegal; both are then refused.
module bus_xcvr_gate #(
    parameter int NDIR = 2
) (
    input  logic            rst_n,
    input  logic [NDIR-1:0] oe_n,
    output logic [NDIR-1:0] drv,
    output logic            conflict
);
    // Illegal when more than one path asks to drive.
    always_comb begin
        conflict = ($countones(~oe_n) > 1);
    end

    // Each driver needs reset released, its request, and no conflict.
    for (genvar d = 0; d < NDIR; d++) begin : g_drv
        assign drv[d] = rst_n & ~oe_n[d] & ~conflict;
    end
endmodule

// File: rtl/bus_xcvr.sv
`timescale 1ns/1ps
// Module: bus_xcvr
// 18-bit two-way bus transceiver. Each direction has its own store
// and its own tri-state driver. Index 0 is A-to-B, index 1 is B-to-A.
// Assumes: one system clock; strobes are levels sampled on it.
module bus_xcvr
    import bus_xcvr_pkg::*;
#(
    parameter int W = DATA_W_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ab_oe_n,
    input  logic         ab_pass,
    input  logic         ab_stb,
    input  logic         ab_stb_en_n,
    input  logic         ba_oe_n,
    input  logic         ba_pass,
    input  logic         ba_stb,
    input  logic         ba_stb_en_n,
    inout  wire  [W-1:0] bus_a,
    inout  wire  [W-1:0] bus_b,
    output logic         conflict
);
    localparam int NDIR = 2;

    store_ctrl_t          ctl   [NDIR];
    logic [NDIR-1:0][W-1:0] src;
    logic [NDIR-1:0][W-1:0] val_q;
    logic [NDIR-1:0]      drv;

    // Gather per-direction controls and sources.
    always_comb begin
        ctl[0] = '{pass: ab_pass, stb: ab_stb, stb_en_n: ab_stb_en_n};
        ctl[1] = '{pass: ba_pass, stb: ba_stb, stb_en_n: ba_stb_en_n};
        src[0] = bus_a;
        src[1] = bus_b;
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        bus_xcvr_store #(.W(W)) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl   (ctl[d]),
            .din   (src[d]),
            .val   (val_q[d])
        );
    end

    bus_xcvr_gate #(.NDIR(NDIR)) u_gate (
        .rst_n    (rst_n),
        .oe_n     ({ba_oe_n, ab_oe_n}),
        .drv      (drv),
        .conflict (conflict)
    );

    // Tri-state drivers on the destination buses.
    assign bus_b = drv[0] ? val_q[0] : {W{1'bz}};
    assign bus_a = drv[1] ? val_q[1] : {W{1'bz}};
endmodule

// File: rtl/bus_xcvr_check.sv
`timescale 1ns/1ps
// Module: bus_xcvr_check
// Properties of the transceiver, bound into bus_xcvr.
// Assumes: sources are defined whenever a path loads.
module bus_xcvr_check
    import bus_xcvr_pkg::*;
#(
    parameter int W = DATA_W_DEFAULT
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ab_oe_n,
    input logic         ba_oe_n,
    input store_ctrl_t  ab_ctl,
    input store_ctrl_t  ba_ctl,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] ab_val,
    input logic [W-1:0] ba_val,
    input logic         drv_ab,
    input logic         drv_ba,
    input logic         conflict
);
    logic ab_prev, ba_prev;
    logic ab_rise, ba_rise;

    // Independent record of the previous strobe levels.
    always_ff @(posedge clk) begin
        ab_prev <= ab_ctl.stb;
        ba_prev <= ba_ctl.stb;
    end
    assign ab_rise = ab_ctl.stb & ~ab_prev;
    assign ba_rise = ba_ctl.stb & ~ba_prev;

    // R8: no driver while reset is held.
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r8_quiet_in_reset: assert (!drv_ab && !drv_ba);
        end
    end

    a_r2_ab_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        ab_oe_n |-> !drv_ab);
    a_r2_ba_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        ba_oe_n |-> !drv_ba);

    a_r9_conflict_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_oe_n && !ba_oe_n) |-> (conflict && !drv_ab && !drv_ba));

    a_r5_ab_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ab_ctl.pass && !$past(ab_ctl.pass)
         && !($past(ab_rise) && !$past(ab_ctl.stb_en_n))) |-> $stable(ab_val));
    a_r5_ba_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ba_ctl.pass && !$past(ba_ctl.pass)
         && !($past(ba_rise) && !$past(ba_ctl.stb_en_n))) |-> $stable(ba_val));

    a_r4_ab_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ab_ctl.pass) && $past(ab_rise)
         && !$past(ab_ctl.stb_en_n) && !ab_ctl.pass) |-> (ab_val == $past(a_in)));
    a_r4_ba_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ba_ctl.pass) && $past(ba_rise)
         && !$past(ba_ctl.stb_en_n) && !ba_ctl.pass) |-> (ba_val == $past(b_in)));
endmodule

bind bus_xcvr bus_xcvr_check #(.W(W)) u_bus_xcvr_check (
    .clk      (clk),
    .rst_n    (rst_n),
    .ab_oe_n  (ab_oe_n),
    .ba_oe_n  (ba_oe_n),
    .ab_ctl   (ctl[0]),
    .ba_ctl   (ctl[1]),
    .a_in     (src[0]),
    .b_in     (src[1]),
    .ab_val   (val_q[0]),
    .ba_val   (val_q[1]),
    .drv_ab   (drv[0]),
    .drv_ba   (drv[1]),
    .conflict (conflict)
);

// File: tb/bus_xcvr_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model, compared on every falling edge.
module bus_xcvr_bench;
    localparam int W = 18;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic clk = 1'b0;
    logic rst_n;
    logic ab_oe_n, ab_pass, ab_stb, ab_stb_en_n;
    logic ba_oe_n, ba_pass, ba_stb, ba_stb_en_n;
    logic a_en, b_en;
    logic [W-1:0] a_val, b_val;
    wire  [W-1:0] bus_a, bus_b;
    logic conflict;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    string cur_req = "R8";

    logic [W-1:0] m_ab, m_ba;
    logic m_ab_seen, m_ba_seen;

    always #10 clk = ~clk;

    assign bus_a = a_en ? a_val : {W{1'bz}};
    assign bus_b = b_en ? b_val : {W{1'bz}};
    for (genvar i = 0; i < W; i++) begin : g_pull
        pullup pu_a (bus_a[i]);
        pullup pu_b (bus_b[i]);
    end

    bus_xcvr #(.W(W)) u_bus_xcvr (
        .clk(clk), .rst_n(rst_n),
        .ab_oe_n(ab_oe_n), .ab_pass(ab_pass), .ab_stb(ab_stb), .ab_stb_en_n(ab_stb_en_n),
        .ba_oe_n(ba_oe_n), .ba_pass(ba_pass), .ba_stb(ba_stb), .ba_stb_en_n(ba_stb_en_n),
        .bus_a(bus_a), .bus_b(bus_b), .conflict(conflict)
    );

    // Reference model: state per direction, updated on the clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ab <= '0;
            m_ba <= '0;
        end else begin
            if (ab_pass || (ab_stb && !m_ab_seen && !ab_stb_en_n)) m_ab <= bus_a;
            if (ba_pass || (ba_stb && !m_ba_seen && !ba_stb_en_n)) m_ba <= bus_b;
        end
        m_ab_seen <= ab_stb;
        m_ba_seen <= ba_stb;
    end

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare ports against the model away from the active edge.
    always @(negedge clk) begin
        logic both;
        logic [W-1:0] exp_a, exp_b;
        both  = !ab_oe_n && !ba_oe_n;
        exp_b = (!rst_n || ab_oe_n || both) ? ONES : (ab_pass ? bus_a : m_ab);
        exp_a = (!rst_n || ba_oe_n || both) ? ONES : (ba_pass ? bus_b : m_ba);
        if (!b_en) chk(cur_req, bus_b, exp_b);
        if (!a_en) chk(cur_req, bus_a, exp_a);
        chk("R9", {{(W-1){1'b0}}, conflict}, {{(W-1){1'b0}}, both});
    end

    task automatic step(int n);
        repeat (n) begin
            @(negedge clk);
            #2;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R8: reset with a drive request pending.
        rst_n = 0;
        ab_oe_n = 0; ab_pass = 0; ab_stb = 0; ab_stb_en_n = 1;
        ba_oe_n = 1; ba_pass = 0; ba_stb = 0; ba_stb_en_n = 1;
        a_en = 1; a_val = 18'h15555; b_en = 0; b_val = '0;
        step(3);
        rst_n = 1; step(2);                       // R8: cleared store shows zero
        // R1, R3: pass-through patterns
        cur_req = "R1"; ab_pass = 1;
        a_val = 18'h2AAAA; step(1);
        a_val = 18'h00001; step(1);
        cur_req = "R3";
        a_val = 18'h20000; step(1);
        a_val = 18'h3FFFE; step(1);
        // R7: pass falls with strobe high and enable low
        a_val = 18'h12345; ab_stb = 1; ab_stb_en_n = 0; step(1);
        cur_req = "R7"; ab_pass = 0; a_val = 18'h0F0F0; step(3);
        // R4: capture on strobe edge
        ab_stb = 0; step(1);
        cur_req = "R4"; a_val = 18'h2B3C4; ab_stb = 1; step(2);
        // R5: steady strobe holds
        cur_req = "R5"; a_val = 18'h01010; step(2);
        ab_stb = 0; a_val = 18'h3C3C3; step(2);
        cur_req = "R4"; ab_stb = 1; step(2);
        // R6: enable qualification at the same edge
        ab_stb = 0; step(1);
        cur_req = "R6"; ab_stb_en_n = 1; a_val = 18'h11111; ab_stb = 1; step(2);
        ab_stb = 0; step(1);
        ab_stb_en_n = 0; ab_stb = 1; a_val = 18'h22222; step(2);
        ab_stb = 0; step(1);
        ab_stb_en_n = 1; ab_stb = 1; a_val = 18'h33333; step(2);
        // R2: isolation, capture while isolated
        cur_req = "R2"; ab_oe_n = 1; step(2);
        ab_stb = 0; step(1);
        ab_stb_en_n = 0; ab_stb = 1; a_val = 18'h00F00; step(1);
        ab_oe_n = 0; step(2);
        // Hand buses over to the B-to-A path
        ab_oe_n = 1; ab_stb_en_n = 1; ab_stb = 0; a_en = 0;
        b_en = 1; b_val = 18'h0AAAA; ba_oe_n = 0; ba_pass = 1;
        cur_req = "R3"; step(2);
        b_val = 18'h35555; step(1);
        cur_req = "R4"; ba_pass = 0; b_val = 18'h00777; ba_stb_en_n = 0; ba_stb = 1; step(2);
        cur_req = "R5"; b_val = 18'h0ABCD; step(2);
        cur_req = "R2"; ba_oe_n = 1; step(2);
        // R9: both drive requests
        cur_req = "R9"; ba_oe_n = 0; ab_oe_n = 0; step(2);
        ab_oe_n = 1; step(2);
        // R8: reset mid-run, strobe held high across release
        cur_req = "R8"; rst_n = 0; step(2);
        rst_n = 1; step(2);
        done = 1;
        summary();
        $finish;
    end
endmodule